// File: doc/BRIEF.md
# Sector Row/Column Parity Engine

This block computes a single-error-correcting parity code over the bytes of one 512-byte flash sector while they cross the data bus. It holds four independent contexts, one per chip select. The host starts a context by writing its arm bit. Each byte accepted while that chip select is active and the context is armed is folded into two 12-bit parity sets. After the last byte of the sector the context stops by itself and keeps its result until it is read.

Each 12-bit position is the byte index (9 bits) joined to the bit index within the byte (3 bits). The first set, the "one" set, XORs the position of every data bit that is 1. The second set, the "zero" set, XORs the inverted position of every such bit. The result port gives the raw word. It also gives a packed 24-bit code. The code is inverted so that an erased sector, which is all 0xFF, yields a code that is itself all ones. The XOR of a stored code and a recomputed code points directly at a single flipped bit.

The byte input uses a valid/ready handshake. Ready is held high at all times and the block never applies back-pressure, so a byte is taken on every clock edge where valid is high. The arm write and the result read are plain strobes.

Top module: `ecc1_engine`

## Requirements
- R1: After reset every context is disarmed and holds zero, so `rd_raw` reads 0 and `rd_code` reads 24'hFFFFFF for every chip select.
- R2: A cycle with `ctl_we` high and `ctl_wdata[8+k]` set arms context k from the next cycle, zeroing its parity and its byte index. A write with none of those bits set arms nothing.
- R3: `s_ready` is always 1. A byte with `s_valid` high updates only the context selected by `s_cs`, and only if that context is armed. Bytes sent to a disarmed context leave its result unchanged.
- R4: For byte index a (0 for the first byte after arming) and bit b, let p = {a[8:0], b[2:0]}. Over all data bits that are 1, `rd_raw[27:16]` is the XOR of p and `rd_raw[11:0]` is the XOR of ~p. `rd_raw[15:12]` is 0.
- R5: After its 512th accepted byte a context disarms itself. Later bytes for that chip select are ignored and the result is held.
- R6: With `rd_en` high, `rd_raw` and `rd_code` show context `rd_cs` in the same cycle, and that context's parity reads zero from the next cycle. Its armed state and byte index are not changed.
- R7: `rd_code` = ~{`rd_raw[27:16]`, `rd_raw[11:0]`}. `rd_code[7:0]` is the first byte stored.
- R8: A full sector of 0xFF bytes yields `rd_code` = 24'hFFFFFF.
- R9: Flipping one data bit at byte a and bit b changes the code by d, where d[23:12] ^ d[11:0] = 12'hFFF and d[23:12] = {a, b}.
- R10: An arm in the same cycle as a byte for that context discards the byte. A read clear in the same cycle as an accepted byte leaves only that byte's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Byte valid |
| s_ready | output | 1 | Always 1 |
| s_data | input | 8 | Data byte |
| s_cs | input | 2 | Chip select the byte belongs to |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 (bits 11:8) | Arm bits, bit 8+k arms context k |
| rd_en | input | 1 | Result read strobe (clears the context) |
| rd_cs | input | 2 | Context to read |
| rd_raw | output | 28 | Raw result word |
| rd_code | output | 24 | Packed, inverted code |

## Verification
An arm write takes effect at the next rising edge. An accepted byte is visible on `rd_raw` after the edge that takes it. The read outputs are combinational from `rd_cs`, so a read value is due in the same cycle as `rd_en`, and the clear shows on the following cycle. The bench drives inputs on the falling edge. It samples the read outputs 1 ns after driving `rd_en`, and it checks a clear by reading again on a later cycle.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  // Per-context update chosen for one cycle
  typedef enum logic [2:0] {
    CTX_IDLE,
    CTX_ARM,
    CTX_CLR,
    CTX_ACC,
    CTX_CLR_ACC
  } ctx_act_e;
endpackage

// File: rtl/ecc1_contrib.sv
// Parity contribution of one byte at a given byte index
module ecc1_contrib #(
  parameter int ADDR_W = 9,
  localparam int HALF_W = ADDR_W + 3
) (
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [HALF_W-1:0] one_o,
  output logic [HALF_W-1:0] zero_o
);
  logic [2:0] col_one, col_zero;
  logic       byte_par;

  always_comb begin
    col_one  = '0;
    col_zero = '0;
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (((i >> b) & 1) == 1) col_one[b]  = col_one[b]  ^ data_i[i];
        else                     col_zero[b] = col_zero[b] ^ data_i[i];
      end
    end
  end

  assign byte_par = ^data_i;
  assign one_o  = {(byte_par ? addr_i  : '0), col_one};
  assign zero_o = {(byte_par ? ~addr_i : '0), col_zero};
endmodule

// File: rtl/ecc1_ctx.sv
// One chip-select context: armed flag, byte index and two parity sets
module ecc1_ctx
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES),
  localparam int HALF_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [HALF_W-1:0] one_in,
  input  logic [HALF_W-1:0] zero_in,
  output logic              acc_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [HALF_W-1:0] one_o,
  output logic [HALF_W-1:0] zero_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SECTOR_BYTES - 1);

  logic              armed_q;
  logic [ADDR_W-1:0] idx_q;
  logic [HALF_W-1:0] one_q, zero_q;
  logic              acc;
  ctx_act_e          act;

  always_comb begin
    acc = take_i && armed_q && !arm_i;
    if (arm_i)               act = CTX_ARM;
    else if (clr_i && acc)   act = CTX_CLR_ACC;
    else if (clr_i)          act = CTX_CLR;
    else if (acc)            act = CTX_ACC;
    else                     act = CTX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      one_q   <= '0;
      zero_q  <= '0;
    end else begin
      case (act)
        CTX_ARM: begin
          armed_q <= 1'b1;
          idx_q   <= '0;
          one_q   <= '0;
          zero_q  <= '0;
        end
        CTX_CLR: begin
          one_q  <= '0;
          zero_q <= '0;
        end
        CTX_ACC, CTX_CLR_ACC: begin
          one_q  <= (act == CTX_ACC ? one_q  : '0) ^ one_in;
          zero_q <= (act == CTX_ACC ? zero_q : '0) ^ zero_in;
          idx_q  <= idx_q + 1'b1;
          if (idx_q == LAST) armed_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign acc_o  = acc;
  assign idx_o  = idx_q;
  assign one_o  = one_q;
  assign zero_o = zero_q;

  // R2
  arm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (armed_q && idx_q == '0 && one_q == '0 && zero_q == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_i && !clr_i) |=> ($stable(one_q) && $stable(zero_q) && !armed_q));

  // R5
  self_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> ($past(idx_q) == LAST));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !arm_i && !acc) |=> (one_q == '0 && zero_q == '0 && $stable(armed_q) && $stable(idx_q)));
endmodule

// File: rtl/ecc1_engine.sv
module ecc1_engine #(
  parameter int NUM_CS       = 4,
  parameter int SECTOR_BYTES = 512,
  parameter int ARM_LSB      = 8,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int ADDR_W = $clog2(SECTOR_BYTES),
  localparam int HALF_W = ADDR_W + 3,
  localparam int RAW_W  = 16 + HALF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [7:0]                    s_data,
  input  logic [CS_W-1:0]               s_cs,
  input  logic                          ctl_we,
  input  logic [ARM_LSB+NUM_CS-1:ARM_LSB] ctl_wdata,
  input  logic                          rd_en,
  input  logic [CS_W-1:0]               rd_cs,
  output logic [RAW_W-1:0]              rd_raw,
  output logic [2*HALF_W-1:0]           rd_code
);
  logic [ADDR_W-1:0] idx_v  [NUM_CS];
  logic [HALF_W-1:0] one_v  [NUM_CS];
  logic [HALF_W-1:0] zero_v [NUM_CS];
  logic [NUM_CS-1:0] acc_v;
  logic [HALF_W-1:0] one_in, zero_in;
  logic [HALF_W-1:0] sel_one, sel_zero;

  assign s_ready = 1'b1;

  // One contribution, computed at the byte index of the addressed context
  ecc1_contrib #(.ADDR_W(ADDR_W)) u_contrib (
    .data_i (s_data),
    .addr_i (idx_v[s_cs]),
    .one_o  (one_in),
    .zero_o (zero_in)
  );

  for (genvar k = 0; k < NUM_CS; k++) begin : g_ctx
    ecc1_ctx #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (ctl_we && ctl_wdata[ARM_LSB+k]),
      .clr_i   (rd_en && rd_cs == CS_W'(k)),
      .take_i  (s_valid && s_cs == CS_W'(k)),
      .one_in  (one_in),
      .zero_in (zero_in),
      .acc_o   (acc_v[k]),
      .idx_o   (idx_v[k]),
      .one_o   (one_v[k]),
      .zero_o  (zero_v[k])
    );
  end

  assign sel_one  = one_v[rd_cs];
  assign sel_zero = zero_v[rd_cs];
  assign rd_raw   = {sel_one, {(16-HALF_W){1'b0}}, sel_zero};
  assign rd_code  = ~{rd_raw[RAW_W-1:16], rd_raw[HALF_W-1:0]};

  // R3
  single_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_v));

  // R3
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |-> (acc_v == '0));
endmodule

// File: tb/ecc1_engine_bench.sv
`timescale 1ns/1ps
module ecc1_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic [1:0]  s_cs = '0;
  logic        ctl_we = 1'b0;
  logic [11:8] ctl_wdata = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic [27:0] rd_raw;
  logic [23:0] rd_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] sbuf [0:511];

  always #2.5 clk = ~clk;

  ecc1_engine u_ecc1_engine (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_cs(s_cs), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_en(rd_en), .rd_cs(rd_cs), .rd_raw(rd_raw), .rd_code(rd_code)
  );

  // stimulus table: {cs, pattern, seed, byte count}
  localparam logic [21:0] TBL [6] = '{
    {2'd0, 2'd0, 8'hFF, 10'd512},
    {2'd1, 2'd0, 8'h00, 10'd512},
    {2'd2, 2'd1, 8'h13, 10'd512},
    {2'd3, 2'd2, 8'hA5, 10'd512},
    {2'd0, 2'd3, 8'h4C, 10'd512},
    {2'd1, 2'd1, 8'h07, 10'd100}
  };

  function automatic logic [7:0] gen(input logic [1:0] mode, input logic [7:0] seed, input int a);
    logic [8:0] ai = 9'(a);
    case (mode)
      2'd0: return seed;
      2'd1: return ai[7:0] + seed;
      2'd2: return ai[7:0] ^ {ai[8], seed[6:0]};
      default: return (ai[7:0] == seed) ? (8'h01 << seed[2:0]) : 8'h00;
    endcase
  endfunction

  // R4 reference: XOR of positions of every 1 bit
  function automatic logic [27:0] model(input int first, input int n);
    logic [11:0] o = '0;
    logic [11:0] z = '0;
    for (int a = first; a < first + n; a++)
      for (int b = 0; b < 8; b++)
        if (sbuf[a][b]) begin
          o = o ^ {9'(a), 3'(b)};
          z = z ^ ~{9'(a), 3'(b)};
        end
    return {o, 4'h0, z};
  endfunction

  function automatic logic [23:0] pack(input logic [27:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [3:0] m);
    ctl_we = 1'b1; ctl_wdata = m;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic send(input logic [1:0] cs, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      s_valid = 1'b1; s_cs = cs; s_data = sbuf[i];
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] cs, output logic [27:0] raw, output logic [23:0] code);
    rd_en = 1'b1; rd_cs = cs;
    #1;
    raw = rd_raw; code = rd_code;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [27:0] raw, exp_raw;
    logic [23:0] code, c1, c2, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), raw, code);
      chk("R1 raw", 32'(raw), 32'h0);
      chk("R1 code", 32'(code), 32'hFFFFFF);
    end
    chk("R3 ready", 32'(s_ready), 32'h1);

    // table walk: R4, R7, R6, R8
    for (int t = 0; t < 6; t++) begin
      logic [1:0] cs = TBL[t][21:20];
      int n = int'(TBL[t][9:0]);
      for (int a = 0; a < 512; a++) sbuf[a] = gen(TBL[t][19:18], TBL[t][17:10], a);
      exp_raw = model(0, n);
      arm(4'b1 << cs);
      send(cs, 0, n);
      rd(cs, raw, code);
      chk("R4 raw", 32'(raw), 32'(exp_raw));
      chk("R7 code", 32'(code), 32'(pack(exp_raw)));
      if (t == 0) chk("R8 erased", 32'(code), 32'hFFFFFF);
      rd(cs, raw, code);
      chk("R6 cleared", 32'(raw), 32'h0);
    end

    for (int a = 0; a < 512; a++) sbuf[a] = gen(2'd1, 8'h3B, a);

    // R3 isolation: arm 0 and 1, feed cs1 only
    arm(4'b0011);
    send(2'd1, 0, 40);
    rd(2'd0, raw, code);
    chk("R3 other ctx", 32'(raw), 32'h0);
    rd(2'd1, raw, code);
    chk("R3 selected ctx", 32'(raw), 32'(model(0, 40)));

    // R3 disarmed context: cs2 done earlier, not re-armed
    send(2'd2, 0, 20);
    rd(2'd2, raw, code);
    chk("R3 disarmed", 32'(raw), 32'h0);

    // R2 write without arm bits
    ctl_we = 1'b1; ctl_wdata = 4'b0000;
    @(negedge clk);
    ctl_we = 1'b0;
    send(2'd2, 0, 20);
    rd(2'd2, raw, code);
    chk("R2 no arm", 32'(raw), 32'h0);

    // R5 bytes past the sector are ignored
    arm(4'b1000);
    send(2'd3, 0, 512);
    sbuf[0] = 8'h81; sbuf[1] = 8'h7E;
    send(2'd3, 0, 2);
    for (int a = 0; a < 2; a++) sbuf[a] = gen(2'd1, 8'h3B, a);
    rd(2'd3, raw, code);
    chk("R5 held", 32'(raw), 32'(model(0, 512)));

    // R9 single bit flip
    arm(4'b0100);
    send(2'd2, 0, 512);
    rd(2'd2, raw, c1);
    sbuf[300] = sbuf[300] ^ 8'h20;
    arm(4'b0100);
    send(2'd2, 0, 512);
    rd(2'd2, raw, c2);
    d = c1 ^ c2;
    chk("R9 halves", 32'(d[23:12] ^ d[11:0]), 32'hFFF);
    chk("R9 locate", 32'(d[23:12]), {20'h0, 9'd300, 3'd5});
    sbuf[300] = sbuf[300] ^ 8'h20;

    // R6 read keeps arming and index
    arm(4'b0001);
    send(2'd0, 0, 10);
    rd(2'd0, raw, code);
    chk("R6 first part", 32'(raw), 32'(model(0, 10)));
    send(2'd0, 10, 10);
    rd(2'd0, raw, code);
    chk("R6 continues", 32'(raw), 32'(model(10, 10)));

    // R10 arm with byte in same cycle drops the byte
    arm(4'b0001);
    send(2'd0, 0, 3);
    ctl_we = 1'b1; ctl_wdata = 4'b0001;
    s_valid = 1'b1; s_cs = 2'd0; s_data = 8'hC3;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0; s_valid = 1'b0;
    send(2'd0, 0, 1);
    rd(2'd0, raw, code);
    chk("R10 arm drops byte", 32'(raw), 32'(model(0, 1)));

    // R10 clear with byte keeps only that byte
    arm(4'b0010);
    send(2'd1, 0, 4);
    rd_en = 1'b1; rd_cs = 2'd1;
    s_valid = 1'b1; s_cs = 2'd1; s_data = sbuf[4];
    #1;
    chk("R6 same-cycle value", 32'(rd_raw), 32'(model(0, 4)));
    @(negedge clk);
    rd_en = 1'b0; s_valid = 1'b0;
    rd(2'd1, raw, code);
    chk("R10 clear with byte", 32'(raw), 32'(model(4, 1)));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule